// File: doc/BRIEF.md
# Framer Service Summary and Interrupt Aggregator

This block condenses the service needs of a line framer into one byte. Four sub-blocks (the bit-error tester, the HDLC controller, the far-end alarm channel and the framer core) each hand over a latched status vector and the enable mask that goes with it. The block ANDs them bit by bit and ORs the result into one live summary bit per sub-block. Three further summary bits follow a counter-saturation flag and the two loss-of-clock flags directly. None of the summary bits is latched, so each one falls by itself when the sub-block status or its enable is cleared.

A second, summary-level enable register chooses which summary bits may raise the active-high interrupt line, and that line is registered. A host reaches both registers through a small register port: the summary register is read-only at address 08h, and the enable register is read/write at 09h. A host that takes an interrupt reads 08h to find the sub-blocks that need service. It then goes to those sub-blocks' own registers, which lie outside this block.

Top module: `irq_summary_agg`

## Requirements
- R1: Bit 0 of the summary is always 0. Bit positions: 1 counter saturation, 2 bit-error tester, 3 HDLC, 4 far-end alarm channel, 5 framer core, 6 transmit-clock loss, 7 receive-clock loss.
- R2: Each of summary bits 2 to 5 is 1 exactly when some bit i below that sub-block's implemented width has both status[i] and enable[i] set. The implemented widths default to 5, 6, 3 and 8. Status and enable bits at or above the implemented width have no effect.
- R3: Summary bit 1 equals the counter-saturation input, bit 6 equals the transmit-clock-loss input and bit 7 equals the receive-clock-loss input.
- R4: The summary output is combinational. A summary bit drops in the same cycle that its sub-block's status or enable bits clear, with no host write.
- R5: After each rising clock edge, irq equals the OR over all bits of (summary AND summary-enable), both taken as they were just before that edge.
- R6: The summary-enable register sits at address 09h. It resets to 00h and takes reg_wdata on a clock edge with reg_wr high and address 09h. A read of 09h in the same cycle as such a write returns the value from before the write.
- R7: Writes to address 08h, or to any address other than 09h, change neither the summary-enable register nor the summary.
- R8: With reg_rd high at an edge, reg_rdata after that edge holds the summary for address 08h, the enable register for 09h, and 00h for any other address. With reg_rd low it holds 00h.
- R9: During reset, irq is 0 and reg_rdata is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bert_stat | input | 8 | Latched bit-error-tester status |
| bert_en | input | 8 | Bit-error-tester enable mask |
| hdlc_stat | input | 8 | Latched HDLC status |
| hdlc_en | input | 8 | HDLC enable mask |
| feac_stat | input | 8 | Latched far-end alarm channel status |
| feac_en | input | 8 | Far-end alarm channel enable mask |
| frm_stat | input | 8 | Latched framer core status |
| frm_en | input | 8 | Framer core enable mask |
| cnt_sat | input | 1 | An error counter has saturated |
| tx_clk_lost | input | 1 | Transmit clock loss detected |
| rx_clk_lost | input | 1 | Receive clock loss detected |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, one cycle after the request |
| summary | output | 8 | Live summary vector |
| irq | output | 1 | Registered interrupt, active high |

## Verification
Two things can land on the same edge: a host write to the summary-enable register, and a change in the summary caused by sub-block status. A read of address 09h can land on that edge as well. The bench provokes this by driving random status vectors together with random enable writes and reads in one cycle. It judges irq against the summary and the enable as they stood before the edge, and it expects the read to return the old enable, not the value being written.

// File: rtl/irq_summary_pkg.sv
package irq_summary_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_SUMMARY = 8'h08;
    localparam logic [ADDR_W-1:0] ADDR_SUM_EN  = 8'h09;

    localparam int BIT_CNT_SAT = 1;
    localparam int BIT_BERT    = 2;
    localparam int BIT_HDLC    = 3;
    localparam int BIT_FEAC    = 4;
    localparam int BIT_FRM     = 5;
    localparam int BIT_TX_LOSS = 6;
    localparam int BIT_RX_LOSS = 7;
    localparam int NUM_SUB     = 4;

    typedef struct packed {
        logic [DATA_W-1:0] sum_en;
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } agg_state_t;
endpackage

// File: rtl/masked_or.sv
module masked_or #(
    parameter int WIDTH = 8,
    parameter int USED  = 8
) (
    input  logic [WIDTH-1:0] stat,
    input  logic [WIDTH-1:0] en,
    output logic             hit
);
    localparam int EFF = (USED > WIDTH) ? WIDTH : USED;

    logic [WIDTH-1:0] keep;
    logic [WIDTH-1:0] pair;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < EFF) begin : g_on
            assign keep[i] = 1'b1;
        end else begin : g_off
            assign keep[i] = 1'b0;
        end
        assign pair[i] = stat[i] & en[i] & keep[i];
    end

    assign hit = |pair;
endmodule

// File: rtl/summary_build.sv
module summary_build
    import irq_summary_pkg::*;
#(
    parameter int BERT_BITS = 5,
    parameter int HDLC_BITS = 6,
    parameter int FEAC_BITS = 3,
    parameter int FRM_BITS  = 8
) (
    input  logic [NUM_SUB*DATA_W-1:0] sub_stat,
    input  logic [NUM_SUB*DATA_W-1:0] sub_en,
    input  logic                      cnt_sat,
    input  logic                      tx_clk_lost,
    input  logic                      rx_clk_lost,
    output logic [DATA_W-1:0]         summary
);
    localparam int USED [NUM_SUB] = '{BERT_BITS, HDLC_BITS, FEAC_BITS, FRM_BITS};

    logic [NUM_SUB-1:0] sub_hit;

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        masked_or #(
            .WIDTH (DATA_W),
            .USED  (USED[s])
        ) u_or (
            .stat (sub_stat[s*DATA_W +: DATA_W]),
            .en   (sub_en[s*DATA_W +: DATA_W]),
            .hit  (sub_hit[s])
        );
    end

    always_comb begin
        summary              = '0;
        summary[BIT_CNT_SAT] = cnt_sat;
        summary[BIT_BERT]    = sub_hit[0];
        summary[BIT_HDLC]    = sub_hit[1];
        summary[BIT_FEAC]    = sub_hit[2];
        summary[BIT_FRM]     = sub_hit[3];
        summary[BIT_TX_LOSS] = tx_clk_lost;
        summary[BIT_RX_LOSS] = rx_clk_lost;
    end
endmodule

// File: rtl/reg_decode.sv
module reg_decode
    import irq_summary_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] summary,
    input  logic [DATA_W-1:0] sum_en_q,
    output logic [DATA_W-1:0] sum_en_d,
    output logic [DATA_W-1:0] rdata_d
);
    always_comb begin
        sum_en_d = sum_en_q;
        if (wr && addr == ADDR_SUM_EN) begin
            sum_en_d = wdata;
        end

        rdata_d = '0;
        if (rd) begin
            unique case (addr)
                ADDR_SUMMARY: rdata_d = summary;
                ADDR_SUM_EN:  rdata_d = sum_en_q;
                default:      rdata_d = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_summary_agg.sv
module irq_summary_agg
    import irq_summary_pkg::*;
#(
    parameter int BERT_BITS = 5,
    parameter int HDLC_BITS = 6,
    parameter int FEAC_BITS = 3,
    parameter int FRM_BITS  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bert_stat,
    input  logic [7:0] bert_en,
    input  logic [7:0] hdlc_stat,
    input  logic [7:0] hdlc_en,
    input  logic [7:0] feac_stat,
    input  logic [7:0] feac_en,
    input  logic [7:0] frm_stat,
    input  logic [7:0] frm_en,
    input  logic       cnt_sat,
    input  logic       tx_clk_lost,
    input  logic       rx_clk_lost,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_rd,
    output logic [7:0] reg_rdata,
    output logic [7:0] summary,
    output logic       irq
);
    agg_state_t state_d, state_q;

    logic [DATA_W-1:0] sum_en_d;
    logic [DATA_W-1:0] rdata_d;

    summary_build #(
        .BERT_BITS (BERT_BITS),
        .HDLC_BITS (HDLC_BITS),
        .FEAC_BITS (FEAC_BITS),
        .FRM_BITS  (FRM_BITS)
    ) u_sum (
        .sub_stat    ({frm_stat, feac_stat, hdlc_stat, bert_stat}),
        .sub_en      ({frm_en, feac_en, hdlc_en, bert_en}),
        .cnt_sat     (cnt_sat),
        .tx_clk_lost (tx_clk_lost),
        .rx_clk_lost (rx_clk_lost),
        .summary     (summary)
    );

    reg_decode u_regs (
        .addr     (reg_addr),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .wdata    (reg_wdata),
        .summary  (summary),
        .sum_en_q (state_q.sum_en),
        .sum_en_d (sum_en_d),
        .rdata_d  (rdata_d)
    );

    always_comb begin
        state_d        = state_q;
        state_d.sum_en = sum_en_d;
        state_d.rdata  = rdata_d;
        state_d.irq    = |(summary & state_q.sum_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata = state_q.rdata;
    assign irq       = state_q.irq;
endmodule

// File: rtl/irq_summary_chk.sv
module irq_summary_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] summary,
    input logic [7:0] sum_en_q,
    input logic       irq,
    input logic [7:0] reg_rdata,
    input logic [7:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       reg_rd,
    input logic [7:0] bert_en,
    input logic       cnt_sat,
    input logic       tx_clk_lost,
    input logic       rx_clk_lost
);
    p_bit0_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        summary[0] == 1'b0);

    p_bert_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bert_en == 8'h00) |-> !summary[2]);

    p_direct_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        summary[1] == cnt_sat && summary[6] == tx_clk_lost && summary[7] == rx_clk_lost);

    p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == |($past(summary) & $past(sum_en_q)));

    p_en_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h09) |=> sum_en_q == $past(reg_wdata));

    p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 8'h09) |=> $stable(sum_en_q));

    p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> reg_rdata == 8'h00);
endmodule

bind irq_summary_agg irq_summary_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .summary     (summary),
    .sum_en_q    (state_q.sum_en),
    .irq         (irq),
    .reg_rdata   (reg_rdata),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rd      (reg_rd),
    .bert_en     (bert_en),
    .cnt_sat     (cnt_sat),
    .tx_clk_lost (tx_clk_lost),
    .rx_clk_lost (rx_clk_lost)
);

// File: tb/tb_irq_summary_agg.sv
module tb_irq_summary_agg;
    localparam int BB = 5, HB = 6, FB = 3, RB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bert_stat = '0, bert_en = '0, hdlc_stat = '0, hdlc_en = '0;
    logic [7:0] feac_stat = '0, feac_en = '0, frm_stat = '0, frm_en = '0;
    logic       cnt_sat = 1'b0, tx_clk_lost = 1'b0, rx_clk_lost = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_rdata, summary;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] en_m = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_summary_agg dut (.*);

    function automatic logic [7:0] lowmask(input int n);
        logic [8:0] m;
        m = (9'd1 << n) - 9'd1;
        return m[7:0];
    endfunction

    function automatic logic [7:0] exp_sum();
        logic [7:0] s;
        s    = '0;
        s[1] = cnt_sat;
        s[2] = |(bert_stat & bert_en & lowmask(BB));
        s[3] = |(hdlc_stat & hdlc_en & lowmask(HB));
        s[4] = |(feac_stat & feac_en & lowmask(FB));
        s[5] = |(frm_stat & frm_en & lowmask(RB));
        s[6] = tx_clk_lost;
        s[7] = rx_clk_lost;
        return s;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle; called at a negative edge with status inputs already set.
    task automatic cycle(input logic wr, input logic rd, input logic [7:0] addr,
                         input logic [7:0] wdata, input string req);
        logic [7:0] es, erd;
        logic       eirq;
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wdata;
        #1;
        es = exp_sum();
        check({req, " summary R1 R2 R3 R4"}, summary, es);
        eirq = |(es & en_m);
        erd  = !rd ? 8'h00 : (addr == 8'h08) ? es : (addr == 8'h09) ? en_m : 8'h00;
        if (wr && addr == 8'h09) en_m = wdata;
        @(posedge clk);
        @(negedge clk);
        check({req, " irq R5"}, {7'd0, irq}, {7'd0, eirq});
        check({req, " rdata R8"}, reg_rdata, erd);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset irq", {7'd0, irq}, 8'h00);
        check("R9 reset rdata", reg_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: enable resets to zero
        cycle(1'b0, 1'b1, 8'h09, 8'h00, "R6 reset enable");
        check("R6 enable after reset", en_m, 8'h00);

        // R2: unimplemented bits ignored (feac uses 3 bits)
        feac_stat = 8'hF8; feac_en = 8'hF8;
        cycle(1'b0, 1'b1, 8'h08, 8'h00, "R2 upper feac bits");
        check("R2 feac bit low", summary, 8'h00);
        feac_stat = 8'h04; feac_en = 8'h04;
        cycle(1'b0, 1'b1, 8'h08, 8'h00, "R2 feac bit2");
        // R4: enable cleared drops bit with no write
        feac_en = 8'h00; #1;
        check("R4 feac cleared", summary, 8'h00);
        @(negedge clk);

        // R3: direct bits
        cnt_sat = 1'b1; tx_clk_lost = 1'b1; rx_clk_lost = 1'b1;
        cycle(1'b0, 1'b1, 8'h08, 8'h00, "R3 direct");
        // R5: irq only with enable; write enable then see irq
        cycle(1'b1, 1'b1, 8'h09, 8'h40, "R6 write en same-cycle read");
        cycle(1'b0, 1'b1, 8'h09, 8'h00, "R6 readback");
        tx_clk_lost = 1'b0;
        cycle(1'b0, 1'b0, 8'h00, 8'h00, "R5 summary drops irq");
        // R7: writes to summary and other addresses ignored
        cycle(1'b1, 1'b1, 8'h08, 8'hFF, "R7 write summary");
        cycle(1'b1, 1'b0, 8'h0A, 8'hFF, "R7 write other");
        cycle(1'b0, 1'b1, 8'h09, 8'h00, "R7 enable unchanged");
        cycle(1'b0, 1'b1, 8'h0A, 8'h00, "R8 unmapped read");
        // bit 0 enable has no source
        cnt_sat = 1'b0; rx_clk_lost = 1'b0;
        cycle(1'b1, 1'b0, 8'h09, 8'h01, "R1 bit0 enable");
        cycle(1'b0, 1'b0, 8'h00, 8'h00, "R1 no irq from bit0");

        // Random mix: status changes together with enable writes and reads
        for (int n = 0; n < 2000; n++) begin
            logic [7:0] a;
            bert_stat = 8'($urandom); bert_en = 8'($urandom & $urandom);
            hdlc_stat = 8'($urandom & $urandom); hdlc_en = 8'($urandom & $urandom);
            feac_stat = 8'($urandom); feac_en = 8'($urandom & $urandom);
            frm_stat = 8'($urandom & $urandom & $urandom); frm_en = 8'($urandom & $urandom);
            cnt_sat = 1'($urandom % 5 == 0);
            tx_clk_lost = 1'($urandom % 7 == 0);
            rx_clk_lost = 1'($urandom % 7 == 0);
            case ($urandom % 4)
                0: a = 8'h08;
                1: a = 8'h09;
                2: a = 8'h09;
                default: a = 8'($urandom);
            endcase
            cycle(1'($urandom), 1'($urandom), a, 8'($urandom), "RND R2 R5 R6 R7 R8");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule